// File: doc/BRIEF.md
# Fixed Off-Time PWM Current Controller

This block is the digital timing core of a fixed off-time current regulator for a motor bridge. It runs on the PWM oscillator clock. A synchronised over-current flag from an external sense comparator clears the source-enable latch. The latch then stays clear for a fixed number of oscillator clocks, and during that time the block says which decay path the bridge should use. A 2-bit code sets how the off period divides into a fast-decay stretch followed by a slow-decay stretch, where slow decay means the low-side switches recirculate the current.

When the off period ends, the latch is set again and a blanking window starts. During the window, trips are ignored, so the switching spike when the source turns on does not end the on time early. The window also restarts when the external enable rises or when the direction input changes.

When synchronous rectification is enabled, the block drives the decay-path switches on during the off period. A zero-current flag turns them off for the rest of that period, so the winding current cannot reverse. The comparators, the oscillator and the gate drivers sit outside this block.

Top module: `offtime_pwm_ctrl`

## Requirements
- R1: Reset is synchronous and active high. After reset, `src_en_o` is 1, and `fast_decay_o` and `sync_rect_o` are 0.
- R2: A trip is accepted when all of these hold: `trip_i` is high at a clock edge, no off period is running, and no blanking window is running. An accepted trip drives `src_en_o` low on the next cycle. `src_en_o` then stays low for exactly OFF_CLKS cycles (96 by default) and returns to 1.
- R3: The decay code sets how many leading cycles of the off period have `fast_decay_o` high: code 0 gives 0, code 1 gives 14, code 2 gives 46, and code 3 gives 96. These are 0%, 15%, 48% and 100% of 96, rounded down. The remaining cycles of the off period are slow decay, with `fast_decay_o` low. `fast_decay_o` is 0 outside off periods.
- R4: The decay code is captured when a trip is accepted. A change of `decay_sel_i` during an off period does not alter that period's decay pattern.
- R5: With `sr_en_i` high, `sync_rect_o` is high from the first cycle of an off period. After `zero_i` is seen high at a clock edge inside the off period, `sync_rect_o` is 0 from the next cycle until the off period ends. `sync_rect_o` is 0 whenever the source is enabled.
- R6: When an off period ends, a blanking window starts. Its length is 6 cycles when `blank_long_i` is 0 and 12 cycles when it is 1. Trips sampled at the 6 (or 12) edges after the off period ends are ignored, and a trip held high is accepted at the next edge after that.
- R7: Outside an off period, a rising `enable_i` or any change of `dir_i` restarts the blanking window, using the same lengths as R6. A trip sampled on the same edge as the restart is ignored. A falling `enable_i` does not start a window.
- R8: A trip during an off period neither extends nor restarts that period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| trip_i | input | 1 | Synchronised over-current flag |
| zero_i | input | 1 | Synchronised zero-current flag |
| decay_sel_i | input | 2 | Fast-decay share code (0 slow, 1 15%, 2 48%, 3 fast) |
| blank_long_i | input | 1 | Blanking length select: 0 gives 6 clocks, 1 gives 12 clocks |
| sr_en_i | input | 1 | Synchronous rectification enable |
| enable_i | input | 1 | External enable; a rising edge restarts blanking |
| dir_i | input | 1 | Direction; any change restarts blanking |
| src_en_o | output | 1 | Source-enable latch (1 = source driver on) |
| fast_decay_o | output | 1 | High while the off period is in fast decay |
| sync_rect_o | output | 1 | Synchronous rectification switches on |

## Verification
The hardest case to reach is the exact edge at which a held trip stops being masked. It has to be reached both after an off period ends and after a restart caused by a DIR change or an ENABLE rise. In the restart case the trip arrives on the same edge as the restart. To reach it, the stimulus holds `trip_i` high from a known edge and records the first cycle in which `src_en_o` falls. That cycle must be exactly one past the selected window length. The zero-current cutoff is placed at chosen cycles inside a period. The decay code is swapped in the middle of a period to show that it was captured at the trip.

// File: rtl/offtime_pwm_pkg.sv
package offtime_pwm_pkg;

  typedef enum logic [1:0] {
    DECAY_SLOW   = 2'd0,
    DECAY_MIX_LO = 2'd1,
    DECAY_MIX_HI = 2'd2,
    DECAY_FAST   = 2'd3
  } decay_sel_e;

  // number of leading fast-decay clocks in an off period, rounded down
  function automatic int fast_clks(input decay_sel_e sel, input int off_clks);
    case (sel)
      DECAY_SLOW:   return 0;
      DECAY_MIX_LO: return (off_clks * 15) / 100;
      DECAY_MIX_HI: return (off_clks * 48) / 100;
      default:      return off_clks;
    endcase
  endfunction

endpackage

// File: rtl/offtime_seq.sv
module offtime_seq
  import offtime_pwm_pkg::*;
#(
  parameter int OFF_CLKS = 96
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start_i,
  input  decay_sel_e sel_i,
  output logic       active_o,
  output logic       done_o,
  output logic       fast_o
);
  localparam int CNT_W = $clog2(OFF_CLKS);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OFF_CLKS - 1);

  logic [CNT_W-1:0] cnt_q;
  decay_sel_e       sel_q;

  assign done_o = active_o && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
      sel_q    <= DECAY_SLOW;
      fast_o   <= 1'b0;
    end else if (start_i) begin
      active_o <= 1'b1;
      cnt_q    <= '0;
      sel_q    <= sel_i;
      fast_o   <= (fast_clks(sel_i, OFF_CLKS) > 0);
    end else if (active_o) begin
      if (done_o) begin
        active_o <= 1'b0;
        cnt_q    <= '0;
        fast_o   <= 1'b0;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        fast_o <= (int'(cnt_q) + 1 < fast_clks(sel_q, OFF_CLKS));
      end
    end
  end
endmodule

// File: rtl/blank_timer.sv
module blank_timer #(
  parameter int BLANK_SHORT = 6,
  parameter int BLANK_LONG  = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic long_i,
  output logic busy_o
);
  localparam int BW = $clog2(BLANK_LONG + 1);

  logic [BW-1:0] cnt_q;

  assign busy_o = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load_i)
      cnt_q <= long_i ? BW'(BLANK_LONG) : BW'(BLANK_SHORT);
    else if (busy_o)
      cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/sync_rect_ctl.sv
module sync_rect_ctl (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic active_i,
  input  logic done_i,
  input  logic sr_en_i,
  input  logic zero_i,
  output logic sr_o
);
  logic cut_q;
  logic cut_n;

  assign cut_n = cut_q | zero_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cut_q <= 1'b0;
      sr_o  <= 1'b0;
    end else if (start_i) begin
      cut_q <= 1'b0;
      sr_o  <= sr_en_i;
    end else if (active_i && !done_i) begin
      cut_q <= cut_n;
      sr_o  <= sr_en_i & ~cut_n;
    end else begin
      cut_q <= 1'b0;
      sr_o  <= 1'b0;
    end
  end
endmodule

// File: rtl/offtime_pwm_ctrl.sv
module offtime_pwm_ctrl
  import offtime_pwm_pkg::*;
#(
  parameter int OFF_CLKS    = 96,
  parameter int BLANK_SHORT = 6,
  parameter int BLANK_LONG  = 12
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       trip_i,
  input  logic       zero_i,
  input  logic [1:0] decay_sel_i,
  input  logic       blank_long_i,
  input  logic       sr_en_i,
  input  logic       enable_i,
  input  logic       dir_i,
  output logic       src_en_o,
  output logic       fast_decay_o,
  output logic       sync_rect_o
);
  logic off_active;
  logic off_done;
  logic blank_busy;
  logic en_q;
  logic dir_q;
  logic restart;
  logic trip_ok;

  always_ff @(posedge clk) begin
    // during reset, track the inputs so that reset release is not seen as an edge
    en_q  <= enable_i;
    dir_q <= dir_i;
  end

  assign restart = !off_active && ((enable_i && !en_q) || (dir_i != dir_q));
  assign trip_ok = trip_i && !off_active && !blank_busy && !restart;

  offtime_seq #(.OFF_CLKS(OFF_CLKS)) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start_i  (trip_ok),
    .sel_i    (decay_sel_e'(decay_sel_i)),
    .active_o (off_active),
    .done_o   (off_done),
    .fast_o   (fast_decay_o)
  );

  blank_timer #(.BLANK_SHORT(BLANK_SHORT), .BLANK_LONG(BLANK_LONG)) u_blank (
    .clk    (clk),
    .rst    (rst),
    .load_i (off_done || restart),
    .long_i (blank_long_i),
    .busy_o (blank_busy)
  );

  sync_rect_ctl u_sr (
    .clk      (clk),
    .rst      (rst),
    .start_i  (trip_ok),
    .active_i (off_active),
    .done_i   (off_done),
    .sr_en_i  (sr_en_i),
    .zero_i   (zero_i),
    .sr_o     (sync_rect_o)
  );

  assign src_en_o = !off_active;
endmodule

// File: rtl/offtime_pwm_chk.sv
module offtime_pwm_chk #(
  parameter int OFF_CLKS = 96
) (
  input logic clk,
  input logic rst,
  input logic zero_i,
  input logic src_en_o,
  input logic fast_decay_o,
  input logic sync_rect_o
);
  localparam int LW = $clog2(OFF_CLKS + 2);
  localparam logic [LW-1:0] LMAX = LW'(OFF_CLKS + 1);

  logic [LW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst)
      low_cnt <= '0;
    else if (src_en_o)
      low_cnt <= '0;
    else if (low_cnt != LMAX)
      low_cnt <= low_cnt + 1'b1;
  end

  p_off_len_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(src_en_o) |-> (low_cnt == LW'(OFF_CLKS)));

  p_off_bound_r2: assert property (@(posedge clk) disable iff (rst)
    !src_en_o |-> (low_cnt < LW'(OFF_CLKS)));

  p_fast_in_off_r3: assert property (@(posedge clk) disable iff (rst)
    fast_decay_o |-> !src_en_o);

  p_fast_first_r3: assert property (@(posedge clk) disable iff (rst)
    (!src_en_o && $past(!src_en_o)) |-> !$rose(fast_decay_o));

  p_sr_in_off_r5: assert property (@(posedge clk) disable iff (rst)
    sync_rect_o |-> !src_en_o);

  p_zero_cut_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(!src_en_o && zero_i) && !src_en_o) |-> !sync_rect_o);

  p_blank_after_off_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(src_en_o) |=> src_en_o);
endmodule

bind offtime_pwm_ctrl offtime_pwm_chk #(.OFF_CLKS(OFF_CLKS)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .zero_i       (zero_i),
  .src_en_o     (src_en_o),
  .fast_decay_o (fast_decay_o),
  .sync_rect_o  (sync_rect_o)
);

// File: tb/offtime_pwm_ctrl_bench.sv
`timescale 1ns/1ps
module offtime_pwm_ctrl_bench;
  localparam int OFF = 96;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic trip_i = 0, zero_i = 0, blank_long_i = 0, sr_en_i = 0;
  logic enable_i = 1, dir_i = 0;
  logic [1:0] decay_sel_i = 0;
  logic src_en_o, fast_decay_o, sync_rect_o;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  offtime_pwm_ctrl u_offtime_pwm_ctrl (
    .clk(clk), .rst(rst), .trip_i(trip_i), .zero_i(zero_i),
    .decay_sel_i(decay_sel_i), .blank_long_i(blank_long_i),
    .sr_en_i(sr_en_i), .enable_i(enable_i), .dir_i(dir_i),
    .src_en_o(src_en_o), .fast_decay_o(fast_decay_o), .sync_rect_o(sync_rect_o)
  );

  task automatic check(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_fast(input logic [1:0] c);
    case (c)
      2'd0: return 0;
      2'd1: return 14;
      2'd2: return 46;
      default: return 96;
    endcase
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle(3);
    rst = 1'b0;
    idle(1);
    check("R1", "src_en", src_en_o, 1'b1);
    check("R1", "fast", fast_decay_o, 1'b0);
    check("R1", "sr", sync_rect_o, 1'b0);
  endtask

  // one off period; returns at the first cycle after it ends (blank window running)
  task automatic t_off(input logic [1:0] code, input logic sr, input int zero_at,
                       input bit swap_code, input bit trip_mid);
    int nf;
    idle(20);
    nf = exp_fast(code);
    decay_sel_i = code;
    sr_en_i = sr;
    trip_i = 1'b1;
    @(negedge clk);
    trip_i = 1'b0;
    for (int k = 0; k <= OFF; k++) begin
      check(trip_mid ? "R8" : "R2", "src_en", src_en_o, (k == OFF));
      check(swap_code ? "R4" : "R3", "fast", fast_decay_o, (k < nf));
      check("R5", "sr", sync_rect_o, sr && (k < OFF) && (zero_at < 0 || k <= zero_at));
      zero_i = (k == zero_at);
      if (swap_code && k == 5) decay_sel_i = ~code;
      trip_i = trip_mid && (k == 50);
      if (k < OFF) @(negedge clk);
    end
    zero_i = 1'b0;
    trip_i = 1'b0;
  endtask

  // held trip from the current cycle (j=0) is masked for len further edges
  task automatic expect_mask(input string req, input int len);
    trip_i = 1'b1;
    for (int j = 1; j <= len + 1; j++) begin
      @(negedge clk);
      check(req, "masked trip", src_en_o, (j <= len));
    end
    trip_i = 1'b0;
    idle(OFF + 2);
  endtask

  task automatic t_blank_after_off(input logic lng);
    blank_long_i = lng;
    t_off(2'd1, 1'b0, -1, 1'b0, 1'b0);
    expect_mask("R6", lng ? 12 : 6);
  endtask

  // restart by DIR change or ENABLE rise, with trip on the same edge
  task automatic t_restart(input bit use_dir, input logic lng);
    blank_long_i = lng;
    if (!use_dir) begin
      enable_i = 1'b0;
      idle(20);
    end else begin
      idle(20);
    end
    if (use_dir) dir_i = ~dir_i;
    else enable_i = 1'b1;
    trip_i = 1'b1;
    for (int j = 0; j <= (lng ? 12 : 6) + 1; j++) begin
      @(negedge clk);
      check("R7", use_dir ? "dir restart" : "enable restart", src_en_o, (j <= (lng ? 12 : 6)));
    end
    trip_i = 1'b0;
    idle(OFF + 20);
  endtask

  task automatic t_enable_fall();
    enable_i = 1'b1;
    idle(20);
    enable_i = 1'b0;
    trip_i = 1'b1;
    @(negedge clk);
    trip_i = 1'b0;
    check("R7", "enable fall no blank", src_en_o, 1'b0);
    idle(OFF + 20);
    enable_i = 1'b1;
    idle(20);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_off(2'd0, 1'b1, -1, 1'b0, 1'b0);
    t_off(2'd1, 1'b1, 30, 1'b0, 1'b0);
    t_off(2'd2, 1'b1, 0, 1'b0, 1'b0);
    t_off(2'd3, 1'b0, -1, 1'b0, 1'b0);
    t_off(2'd1, 1'b1, 94, 1'b1, 1'b0);
    t_off(2'd2, 1'b0, -1, 1'b0, 1'b1);
    t_blank_after_off(1'b0);
    t_blank_after_off(1'b1);
    t_restart(1'b1, 1'b0);
    t_restart(1'b1, 1'b1);
    t_restart(1'b0, 1'b0);
    t_restart(1'b0, 1'b1);
    t_enable_fall();
    finish_up();
  end
endmodule